// File: doc/BRIEF.md
# Segment-Glass Display Driver with AC Backplane

This block turns a latched three-and-a-half digit reading into drive signals for a direct-drive liquid-crystal panel. It accepts three BCD digits, a flag for the leading "1", a negative flag, an over-range flag and a lamp-test request. It produces seven-segment patterns for the three low digits, one output for the leading "1" (the panel ties that digit's b and c segments to it), a minus-sign output and a backplane square wave. The backplane comes from a synchronous divider on the oscillator clock.

A segment that should look dark is driven with the same waveform as the backplane. A segment that should look lit is driven with the inverse. The average voltage across every segment is therefore zero. All segment outputs and the backplane come from flops that load on the same clock edge, so the two can never skew.

Over-range blanks the three low digits and forces the leading "1" on; the sign follows the negative flag. Lamp test overrides everything: all segment outputs sit at a constant high level, and the backplane keeps running.

Top module: `lcd_glass_driver`

## Requirements
- R1: After reset the backplane `bp` is low. It inverts on the 400th rising clock edge after reset is released and every 400 edges after that, giving a period of 800 clocks (parameter `BP_HALF`).
- R2: Outside lamp test, each segment output equals `bp` when the segment is dark and the inverse of `bp` when it is lit. The output reflects the inputs sampled on the same edge that loads `bp`, so outputs lag the inputs by one clock.
- R3: Each low digit decodes codes 0 to 9 onto bits [6:0] = {g,f,e,d,c,b,a}, with bit 0 = a. Example patterns: 0 lights a,b,c,d,e,f; 1 lights b,c; 7 lights a,b,c; 6 includes a; 9 includes d.
- R4: A low-digit code from 10 to 15 leaves all seven segments of that digit dark.
- R5: `seg_lead` is lit when `lead_one` is high and dark otherwise.
- R6: `seg_sign` is lit when `neg` is high and dark otherwise.
- R7: While `over_range` is high, all three low digits are dark and `seg_lead` is lit whatever the value of `lead_one`. The sign still follows R6.
- R8: While `lamp_test` is high, every segment output (all 23) is held at constant 1 one clock later, even across `bp` transitions. Lamp test takes priority over over-range, and `bp` keeps toggling per R1.
- R9: While reset is asserted, `bp` and every segment output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_ones | input | 4 | BCD units digit |
| digit_tens | input | 4 | BCD tens digit |
| digit_hund | input | 4 | BCD hundreds digit |
| lead_one | input | 1 | Leading digit shows "1" |
| neg | input | 1 | Reading is negative |
| over_range | input | 1 | Reading exceeds full scale |
| lamp_test | input | 1 | Force every segment on (DC) |
| bp | output | 1 | Backplane square wave |
| seg_ones | output | 7 | Units segments {g..a} |
| seg_tens | output | 7 | Tens segments {g..a} |
| seg_hund | output | 7 | Hundreds segments {g..a} |
| seg_lead | output | 1 | Shared b/c drive of leading "1" |
| seg_sign | output | 1 | Minus-sign segment |

## Verification
Lamp test and over-range blanking can both be requested in the same cycle, and either can coincide with the backplane edge. The stimulus raises both flags together on the clock that precedes each backplane inversion, and it also holds lamp test across several inversions. Such a cycle passes only if every output reads 1 while `bp` still flips on schedule. After the flags drop, the over-range pattern must come back correctly phased against the new backplane level.

// File: rtl/lcdg_pkg.sv
package lcdg_pkg;
  localparam int SEG_W   = 7;
  localparam int NUM_LOW = 3;
  localparam int DRV_W   = NUM_LOW * SEG_W + 2;

  typedef logic [SEG_W-1:0] seg7_t;

  // bit order {g,f,e,d,c,b,a}; codes above nine stay dark
  function automatic seg7_t bcd_to_seg(input logic [3:0] code);
    seg7_t s;
    case (code)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lcdg_bp_div.sv
module lcdg_bp_div #(
  parameter int HALF = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic bp,
  output logic bp_next,
  output logic wrap
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign wrap    = (cnt == LAST);
  assign bp_next = bp ^ wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      bp  <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      bp  <= bp_next;
    end
  end

  // R1
  bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(bp));
  // R1
  bp_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (bp != $past(bp)));
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/lcdg_digit_dec.sv
module lcdg_digit_dec
  import lcdg_pkg::*;
(
  input  logic [3:0] code,
  input  logic       blank,
  output seg7_t      lit
);
  assign lit = blank ? '0 : bcd_to_seg(code);
endmodule

// File: rtl/lcdg_phase_drv.sv
module lcdg_phase_drv #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bp_next,
  input  logic         lamp,
  input  logic [W-1:0] lit,
  output logic [W-1:0] drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      drive <= '0;
    else if (lamp)
      drive <= '1;
    else
      drive <= lit ^ {W{bp_next}};
  end
endmodule

// File: rtl/lcd_glass_driver.sv
module lcd_glass_driver
  import lcdg_pkg::*;
#(
  parameter int BP_HALF = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] digit_ones,
  input  logic [3:0] digit_tens,
  input  logic [3:0] digit_hund,
  input  logic       lead_one,
  input  logic       neg,
  input  logic       over_range,
  input  logic       lamp_test,
  output logic       bp,
  output logic [6:0] seg_ones,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_hund,
  output logic       seg_lead,
  output logic       seg_sign
);
  logic             bp_next;
  logic             bp_wrap;
  logic [3:0]       code  [NUM_LOW];
  seg7_t            lit_low [NUM_LOW];
  logic             lead_lit;
  logic             sign_lit;
  logic [DRV_W-1:0] lit_vec;
  logic [DRV_W-1:0] drv_vec;

  lcdg_bp_div #(.HALF(BP_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .bp(bp), .bp_next(bp_next), .wrap(bp_wrap)
  );

  assign code[0] = digit_ones;
  assign code[1] = digit_tens;
  assign code[2] = digit_hund;

  for (genvar g = 0; g < NUM_LOW; g++) begin : g_low
    lcdg_digit_dec u_dec (.code(code[g]), .blank(over_range), .lit(lit_low[g]));
    assign lit_vec[g*SEG_W +: SEG_W] = lit_low[g];
  end

  assign lead_lit = lead_one | over_range;
  assign sign_lit = neg;
  assign lit_vec[DRV_W-2] = lead_lit;
  assign lit_vec[DRV_W-1] = sign_lit;

  lcdg_phase_drv #(.W(DRV_W)) u_drv (
    .clk(clk), .rst_n(rst_n), .bp_next(bp_next), .lamp(lamp_test),
    .lit(lit_vec), .drive(drv_vec)
  );

  assign seg_ones = drv_vec[0*SEG_W +: SEG_W];
  assign seg_tens = drv_vec[1*SEG_W +: SEG_W];
  assign seg_hund = drv_vec[2*SEG_W +: SEG_W];
  assign seg_lead = drv_vec[DRV_W-2];
  assign seg_sign = drv_vec[DRV_W-1];

  // R6
  sign_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(lamp_test)) |-> (seg_sign == (bp ^ $past(neg))));
  // R8
  lamp_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lamp_test)) |->
      (&seg_ones && &seg_tens && &seg_hund && seg_lead && seg_sign));
  // R7
  over_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(over_range) && !$past(lamp_test)) |->
      (seg_ones == {7{bp}} && seg_tens == {7{bp}} && seg_hund == {7{bp}}
       && seg_lead != bp));
  // R4
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(lamp_test) && ($past(digit_ones) > 4'd9)) |->
      (seg_ones == {7{bp}}));
  // R5
  lead_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(lamp_test) && !$past(over_range)) |->
      (seg_lead == (bp ^ $past(lead_one))));
endmodule

// File: tb/lcd_glass_driver_tb_top.sv
`timescale 1ns/1ps
module lcd_glass_driver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] d1, d10, d100;
  logic       lead, ng, ovr, lamp;
  logic       bp;
  logic [6:0] s1, s10, s100;
  logic       slead, ssign;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  int n     = 0;

  always #10 clk = ~clk;

  lcd_glass_driver dut_i (
    .clk(clk), .rst_n(rst_n), .digit_ones(d1), .digit_tens(d10), .digit_hund(d100),
    .lead_one(lead), .neg(ng), .over_range(ovr), .lamp_test(lamp),
    .bp(bp), .seg_ones(s1), .seg_tens(s10), .seg_hund(s100),
    .seg_lead(slead), .seg_sign(ssign)
  );

  // segment lit sets per digit, written per segment
  function automatic logic [6:0] ref_pattern(input logic [3:0] v);
    logic [6:0] p;
    if (v > 4'd9) return 7'h00;
    p[0] = !(v == 1 || v == 4);                       // a
    p[1] = !(v == 5 || v == 6);                       // b
    p[2] = (v != 2);                                  // c
    p[3] = !(v == 1 || v == 4 || v == 7);             // d
    p[4] = (v == 0 || v == 2 || v == 6 || v == 8);    // e
    p[5] = !(v == 1 || v == 2 || v == 3 || v == 7);   // f
    p[6] = !(v == 0 || v == 1 || v == 7);             // g
    return p;
  endfunction

  function automatic logic [6:0] exp_digit(input logic [3:0] v, input logic o,
                                           input logic l, input logic b);
    if (l) return 7'h7F;
    return (o ? 7'h00 : ref_pattern(v)) ^ {7{b}};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, n);
    end
  endtask

  function automatic string dig_tag(input logic [3:0] v, input logic o, input logic l);
    if (l) return "R8 lamp digit";
    if (o) return "R7 over-range digit";
    if (v > 4'd9) return "R4 bad code";
    return "R2 R3 digit";
  endfunction

  logic [3:0] p1, p10, p100;
  logic       plead, png, povr, plamp;

  task automatic drive_inputs(input int i);
    d1   = 4'($urandom % 16);
    d10  = 4'($urandom % 16);
    d100 = 4'($urandom % 16);
    lead = 1'($urandom % 2);
    ng   = 1'($urandom % 2);
    ovr  = (($urandom % 8) == 0);
    lamp = (($urandom % 16) == 0);
    if (i >= 1000 && i < 1900) lamp = 1'b1;          // long DC hold across bp edges
    if (i >= 2500 && i < 2600) begin ovr = 1'b1; lamp = 1'b0; lead = 1'b0; end
    if (i >= 3000 && i < 3040) begin ovr = 1'b0; lamp = 1'b0; d1 = 4'(10 + (i % 6)); end
    if ((i % 400) == 399 && i >= 3200) begin lamp = 1'b1; ovr = 1'b1; end
    if ((i % 400) == 0 && i >= 3200) begin lamp = 1'b0; ovr = 1'b1; end
    p1 = d1; p10 = d10; p100 = d100; plead = lead; png = ng; povr = ovr; plamp = lamp;
  endtask

  initial begin : watchdog
    #4000000;
    if (!done) begin
      fails++;
      total++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : stim
    logic eb;
    void'($urandom(32'd7411));
    rst_n = 1'b0;
    d1 = 4'd8; d10 = 4'd8; d100 = 4'd8; lead = 1'b1; ng = 1'b1; ovr = 1'b0; lamp = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset bp", 32'(bp), 32'd0);
    chk("R9 reset segments", 32'({s1, s10, s100, slead, ssign}), 32'd0);
    drive_inputs(0);
    rst_n = 1'b1;
    for (int i = 1; i < 6000; i++) begin
      @(negedge clk);
      n++;
      eb = 1'(((n / 400) % 2));
      chk("R1 backplane", 32'(bp), 32'(eb));
      chk(dig_tag(p1, povr, plamp),   32'(s1),   32'(exp_digit(p1, povr, plamp, eb)));
      chk(dig_tag(p10, povr, plamp),  32'(s10),  32'(exp_digit(p10, povr, plamp, eb)));
      chk(dig_tag(p100, povr, plamp), 32'(s100), 32'(exp_digit(p100, povr, plamp, eb)));
      chk(plamp ? "R8 lamp lead" : (povr ? "R7 over-range lead" : "R5 lead"),
          32'(slead), 32'(plamp ? 1'b1 : ((plead | povr) ^ eb)));
      chk(plamp ? "R8 lamp sign" : "R6 sign",
          32'(ssign), 32'(plamp ? 1'b1 : (png ^ eb)));
      drive_inputs(i);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule